// File: doc/BRIEF.md
# Frame-Size-Aware Serial Data FIFO

This block is a synchronous first-in first-out buffer for serial-port data frames. It sits between a register-side writer and a serial shifter. One fixed pool of storage is split into entries whose size follows the configured frame width, so narrow frames get more entries from the same bits. The pool is 32 byte lanes. A frame of up to 8 bits takes one lane, a frame of up to 16 bits takes two lanes, and a wider frame takes four lanes.

A deep-mode input selects the capacity. With deep mode off, the buffer always holds four frames. With deep mode on, the capacity is whatever fits in the pool for the current frame width. Any change to the frame width or to deep mode empties the buffer. This means frames stored under one layout are never read back under another.

The read port is registered. An accepted pop loads the oldest frame into `pop_data_o` at the clock edge. A push while full, or a pop while empty, is rejected and reported by a one-cycle pulse.

Top module: `spi_frame_fifo`

## Requirements
- R1: With `deep_mode_i` low, capacity is 4 frames for every frame width. `full_o` rises after the fourth accepted push, and a fifth push is dropped.
- R2: With `deep_mode_i` high and `frame_bits_i` from 4 to 8, capacity is 32 frames.
- R3: With `deep_mode_i` high and `frame_bits_i` from 9 to 16, capacity is 16 frames.
- R4: With `deep_mode_i` high and `frame_bits_i` from 17 to 32, capacity is 8 frames.
- R5: Frames leave in the order they were pushed. On the clock edge that accepts a pop, `pop_data_o` takes the oldest stored frame and then holds it until the next pop or flush.
- R6: Only the low `frame_bits_i` bits of a pushed word are kept. All bits of `pop_data_o` at and above position `frame_bits_i` read as zero.
- R7: `level_o` counts the stored frames. Each accepted push alone adds one and each accepted pop alone subtracts one. `full_o` is high exactly when `level_o` equals the current capacity, and `empty_o` is high exactly when `level_o` is zero.
- R8: A push while `full_o` is high is dropped, leaving contents and `level_o` unchanged. `overflow_o` is then high for the single cycle after that edge.
- R9: A pop while `empty_o` is high loads zero into `pop_data_o`. `underflow_o` is then high for the single cycle after that edge.
- R10: A flush happens on the clock edge of any cycle in which `frame_bits_i` or `deep_mode_i` differs from its value at the previous edge. The flush empties the buffer and clears `pop_data_o`. Push and pop strobes in that cycle are ignored and raise no pulse.
- R11: While `rst_ni` is low: `empty_o` is 1, `full_o` is 0, `level_o` is 0, `pop_data_o` is 0, and both pulses are 0.
- R12: A push and a pop in the same cycle, when the buffer is neither full nor empty, leave `level_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Write strobe |
| push_data_i | input | 32 | Frame to store, right-aligned |
| pop_i | input | 1 | Read strobe |
| frame_bits_i | input | 6 | Frame width in bits, 4 to 32 |
| deep_mode_i | input | 1 | Selects width-dependent capacity |
| pop_data_o | output | 32 | Last popped frame, registered |
| full_o | output | 1 | Buffer at capacity |
| empty_o | output | 1 | Buffer holds no frame |
| level_o | output | 6 | Number of stored frames |
| overflow_o | output | 1 | One-cycle pulse after a dropped push |
| underflow_o | output | 1 | One-cycle pulse after a pop on empty |

## Verification
The properties assume `frame_bits_i` stays between 4 and 32. Outside that range the masking and the upper-bits-zero check have no defined meaning. The properties also assume that configuration changes are seen only at clock edges, because the checker rebuilds the flush condition from its own copy of the previous configuration. The stimulus sets each configuration, then spends one idle cycle so the flush takes place, and only then issues strobes. The only exception is the flush test, which strobes on purpose in the changing cycle. Every frame width the stimulus uses lies in the legal range, and each capacity class is exercised at both of its edge widths.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int LANE_W = 8;

  // Entry size classes: an entry spans (1 << class) byte lanes.
  typedef enum logic [1:0] {
    CLS_BYTE = 2'd0,
    CLS_HALF = 2'd1,
    CLS_WORD = 2'd2
  } frame_cls_e;
endpackage

// File: rtl/fifo_cfg_decode.sv
module fifo_cfg_decode
  import spi_fifo_pkg::*;
#(
  parameter int FRAME_W       = 32,
  parameter int POOL_LANES    = 32,
  parameter int SHALLOW_DEPTH = 4,
  localparam int LEN_W = $clog2(FRAME_W) + 1,
  localparam int CNT_W = $clog2(POOL_LANES) + 1
) (
  input  logic [LEN_W-1:0]   frame_bits_i,
  input  logic               deep_mode_i,
  output logic [1:0]         cls_o,
  output logic [CNT_W-1:0]   depth_o,
  output logic [FRAME_W-1:0] mask_o
);
  frame_cls_e cls;

  always_comb begin
    if (frame_bits_i <= LEN_W'(LANE_W))          cls = CLS_BYTE;
    else if (frame_bits_i <= LEN_W'(2 * LANE_W)) cls = CLS_HALF;
    else                                         cls = CLS_WORD;
  end

  assign cls_o   = cls;
  assign depth_o = deep_mode_i ? CNT_W'(POOL_LANES >> cls) : CNT_W'(SHALLOW_DEPTH);
  assign mask_o  = ~({FRAME_W{1'b1}} << frame_bits_i);
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl #(
  parameter int POOL_LANES = 32,
  localparam int PTR_W = $clog2(POOL_LANES),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  input  logic [CNT_W-1:0] depth_i,
  output logic             push_ok_o,
  output logic             pop_ok_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic [PTR_W-1:0] rd_idx_o,
  output logic [CNT_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] level_q, level_d;
  logic             ovf_q, ovf_d, unf_q, unf_d;
  logic             full, empty;

  assign full      = (level_q == depth_i);
  assign empty     = (level_q == '0);
  assign push_ok_o = push_i & ~flush_i & ~full;
  assign pop_ok_o  = pop_i & ~flush_i & ~empty;

  always_comb begin
    wr_d    = wr_q;
    rd_d    = rd_q;
    level_d = level_q;
    ovf_d   = push_i & ~flush_i & full;
    unf_d   = pop_i & ~flush_i & empty;
    if (flush_i) begin
      wr_d    = '0;
      rd_d    = '0;
      level_d = '0;
    end else begin
      if (push_ok_o)
        wr_d = (CNT_W'(wr_q) == depth_i - 1'b1) ? '0 : wr_q + 1'b1;
      if (pop_ok_o)
        rd_d = (CNT_W'(rd_q) == depth_i - 1'b1) ? '0 : rd_q + 1'b1;
      if (push_ok_o && !pop_ok_o)      level_d = level_q + 1'b1;
      else if (pop_ok_o && !push_ok_o) level_d = level_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      level_q <= level_d;
      ovf_q   <= ovf_d;
      unf_q   <= unf_d;
    end
  end

  assign wr_idx_o    = wr_q;
  assign rd_idx_o    = rd_q;
  assign level_o     = level_q;
  assign full_o      = full;
  assign empty_o     = empty;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;
endmodule

// File: rtl/fifo_lane_pool.sv
module fifo_lane_pool
  import spi_fifo_pkg::*;
#(
  parameter int FRAME_W    = 32,
  parameter int POOL_LANES = 32,
  localparam int PTR_W     = $clog2(POOL_LANES),
  localparam int MAX_LANES = FRAME_W / LANE_W,
  localparam int SPAN_W    = $clog2(MAX_LANES) + 1
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic [PTR_W-1:0]   wr_idx_i,
  input  logic [PTR_W-1:0]   rd_idx_i,
  input  logic [1:0]         cls_i,
  input  logic [FRAME_W-1:0] wdata_i,
  output logic [FRAME_W-1:0] rdata_o
);
  logic [POOL_LANES*LANE_W-1:0] pool_flat;
  logic [SPAN_W-1:0]            span;
  logic [PTR_W-1:0]             wr_base, rd_base;

  assign span    = SPAN_W'(1) << cls_i;
  assign wr_base = wr_idx_i << cls_i;
  assign rd_base = rd_idx_i << cls_i;

  for (genvar l = 0; l < POOL_LANES; l++) begin : g_lane
    logic [PTR_W-1:0]  ofs;
    logic              hit;
    logic [LANE_W-1:0] byte_q;

    assign ofs = PTR_W'(l) - wr_base;
    assign hit = we_i && (ofs < PTR_W'(span));

    always_ff @(posedge clk_i) begin
      if (hit) byte_q <= wdata_i[ofs[SPAN_W-2:0]*LANE_W +: LANE_W];
    end

    assign pool_flat[l*LANE_W +: LANE_W] = byte_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int j = 0; j < MAX_LANES; j++) begin
      if (SPAN_W'(j) < span)
        rdata_o[j*LANE_W +: LANE_W] = pool_flat[(rd_base + PTR_W'(j))*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/spi_frame_fifo.sv
module spi_frame_fifo
  import spi_fifo_pkg::*;
#(
  parameter int FRAME_W       = 32,
  parameter int POOL_BITS     = 256,
  parameter int SHALLOW_DEPTH = 4,
  localparam int POOL_LANES = POOL_BITS / LANE_W,
  localparam int PTR_W      = $clog2(POOL_LANES),
  localparam int CNT_W      = PTR_W + 1,
  localparam int LEN_W      = $clog2(FRAME_W) + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic [FRAME_W-1:0] push_data_i,
  input  logic               pop_i,
  input  logic [LEN_W-1:0]   frame_bits_i,
  input  logic               deep_mode_i,
  output logic [FRAME_W-1:0] pop_data_o,
  output logic               full_o,
  output logic               empty_o,
  output logic [CNT_W-1:0]   level_o,
  output logic               overflow_o,
  output logic               underflow_o
);
  logic [LEN_W-1:0]   frame_q;
  logic               deep_q;
  logic               flush;
  logic [1:0]         cls;
  logic [CNT_W-1:0]   depth;
  logic [FRAME_W-1:0] mask;
  logic               push_ok, pop_ok;
  logic [PTR_W-1:0]   wr_idx, rd_idx;
  logic [FRAME_W-1:0] pool_rd;
  logic [FRAME_W-1:0] rdata_q, rdata_d;

  assign flush = (frame_bits_i != frame_q) | (deep_mode_i != deep_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      deep_q  <= 1'b0;
    end else begin
      frame_q <= frame_bits_i;
      deep_q  <= deep_mode_i;
    end
  end

  fifo_cfg_decode #(
    .FRAME_W(FRAME_W), .POOL_LANES(POOL_LANES), .SHALLOW_DEPTH(SHALLOW_DEPTH)
  ) u_decode (
    .frame_bits_i(frame_q),
    .deep_mode_i (deep_q),
    .cls_o       (cls),
    .depth_o     (depth),
    .mask_o      (mask)
  );

  fifo_ctrl #(.POOL_LANES(POOL_LANES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .flush_i    (flush),
    .depth_i    (depth),
    .push_ok_o  (push_ok),
    .pop_ok_o   (pop_ok),
    .wr_idx_o   (wr_idx),
    .rd_idx_o   (rd_idx),
    .level_o    (level_o),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .overflow_o (overflow_o),
    .underflow_o(underflow_o)
  );

  fifo_lane_pool #(.FRAME_W(FRAME_W), .POOL_LANES(POOL_LANES)) u_pool (
    .clk_i   (clk_i),
    .we_i    (push_ok),
    .wr_idx_i(wr_idx),
    .rd_idx_i(rd_idx),
    .cls_i   (cls),
    .wdata_i (push_data_i & mask),
    .rdata_o (pool_rd)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (flush)              rdata_d = '0;
    else if (pop_ok)        rdata_d = pool_rd;
    else if (pop_i)         rdata_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign pop_data_o = rdata_q;
endmodule

// File: rtl/spi_frame_fifo_chk.sv
module spi_frame_fifo_chk #(
  parameter int FRAME_W       = 32,
  parameter int SHALLOW_DEPTH = 4,
  parameter int CNT_W         = 6,
  parameter int LEN_W         = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               push_i,
  input logic               pop_i,
  input logic [LEN_W-1:0]   frame_bits_i,
  input logic               deep_mode_i,
  input logic [FRAME_W-1:0] pop_data_o,
  input logic               full_o,
  input logic               empty_o,
  input logic [CNT_W-1:0]   level_o,
  input logic               overflow_o,
  input logic               underflow_o
);
  logic [LEN_W-1:0] seen_bits;
  logic             seen_deep;
  logic             cfg_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_bits <= '0;
      seen_deep <= 1'b0;
    end else begin
      seen_bits <= frame_bits_i;
      seen_deep <= deep_mode_i;
    end
  end

  assign cfg_chg = (frame_bits_i != seen_bits) || (deep_mode_i != seen_deep);

  // R10
  flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_chg |=> (empty_o && level_o == '0 && pop_data_o == '0));

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !cfg_chg) |=> (overflow_o && $stable(level_o)));

  // R9
  underflow_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !cfg_chg) |=> (underflow_o && pop_data_o == '0));

  // R1
  shallow_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!deep_mode_i && !cfg_chg) |-> (level_o <= CNT_W'(SHALLOW_DEPTH)));

  // R7
  level_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full_o && !cfg_chg) |=> (level_o == $past(level_o) + 1'b1));

  // R12
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !full_o && !empty_o && !cfg_chg) |=> $stable(level_o));

  // R6
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_chg && frame_bits_i < LEN_W'(FRAME_W)) |-> ((pop_data_o >> frame_bits_i) == '0));

  // R7
  flag_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
endmodule

bind spi_frame_fifo spi_frame_fifo_chk #(
  .FRAME_W(FRAME_W), .SHALLOW_DEPTH(SHALLOW_DEPTH), .CNT_W(CNT_W), .LEN_W(LEN_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .frame_bits_i(frame_bits_i),
  .deep_mode_i (deep_mode_i),
  .pop_data_o  (pop_data_o),
  .full_o      (full_o),
  .empty_o     (empty_o),
  .level_o     (level_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o)
);

// File: tb/spi_frame_fifo_tb.sv
module spi_frame_fifo_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        push, pop, deep;
  logic [31:0] wdata;
  logic [5:0]  fbits;
  logic [31:0] rdata;
  logic        full, empty, ovf, unf;
  logic [5:0]  level;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_frame_fifo u_dut (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_data_i(wdata), .pop_i(pop),
    .frame_bits_i(fbits), .deep_mode_i(deep), .pop_data_o(rdata), .full_o(full),
    .empty_o(empty), .level_o(level), .overflow_o(ovf), .underflow_o(unf)
  );

  typedef struct packed {
    logic        push;
    logic        pop;
    logic [31:0] data;
    logic [5:0]  level;
    logic        full;
    logic        empty;
    logic        ovf;
    logic        unf;
    logic [31:0] rdata;
  } vec_t;

  // 12-bit frames, shallow mode (capacity 4)
  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 32'h1234_5A01, 6'd1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},
    '{1'b1, 1'b0, 32'hFFFF_FA52, 6'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},
    '{1'b1, 1'b0, 32'h0000_0A53, 6'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},
    '{1'b1, 1'b0, 32'hABCD_EA54, 6'd4, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0},
    '{1'b1, 1'b0, 32'h1111_1111, 6'd4, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0},
    '{1'b0, 1'b1, 32'h0,         6'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'hA01},
    '{1'b1, 1'b1, 32'h0000_0B55, 6'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'hA52},
    '{1'b0, 1'b1, 32'h0,         6'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'hA53},
    '{1'b0, 1'b1, 32'h0,         6'd1, 1'b0, 1'b0, 1'b0, 1'b0, 32'hA54},
    '{1'b0, 1'b1, 32'h0,         6'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'hB55},
    '{1'b0, 1'b1, 32'h0,         6'd0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0},
    '{1'b0, 1'b0, 32'h0,         6'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i, input int seed);
    return (32'(i) * 32'h0101_0101) ^ 32'h9E37_79B9 ^ 32'(seed);
  endfunction

  function automatic logic [31:0] msk(input int bits);
    return (bits >= 32) ? 32'hFFFF_FFFF : ((32'h1 << bits) - 1);
  endfunction

  task automatic configure(input int bits, input logic dm);
    push = 1'b0; pop = 1'b0;
    fbits = 6'(bits); deep = dm;
    @(negedge clk);
  endtask

  task automatic depth_test(input string req, input int bits, input logic dm, input int depth);
    configure(bits, dm);
    for (int i = 0; i < depth; i++) begin
      push = 1'b1; wdata = pat(i, bits);
      @(negedge clk);
      chk({req, " level after push"}, 32'(level), 32'(i + 1));
      chk({req, " full flag (R7)"}, 32'(full), 32'(i == depth - 1));
    end
    wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    chk({req, " R8 overflow pulse"}, 32'(ovf), 32'd1);
    chk({req, " R8 level held"}, 32'(level), 32'(depth));
    push = 1'b0;
    for (int i = 0; i < depth; i++) begin
      pop = 1'b1;
      @(negedge clk);
      chk({req, " R5/R6 pop order and mask"}, rdata, pat(i, bits) & msk(bits));
    end
    pop = 1'b0;
    chk({req, " R7 empty after drain"}, 32'(empty), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; push = 1'b0; pop = 1'b0; wdata = '0; fbits = 6'd12; deep = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 empty", 32'(empty), 32'd1);
    chk("R11 full", 32'(full), 32'd0);
    chk("R11 level", 32'(level), 32'd0);
    chk("R11 rdata", rdata, 32'd0);
    chk("R11 pulses", {30'd0, ovf, unf}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk); // configuration settles (flush cycle)

    // Table walk: R1 R5 R6 R7 R8 R9 R12
    for (int v = 0; v < NVEC; v++) begin
      push = VECS[v].push; pop = VECS[v].pop; wdata = VECS[v].data;
      @(negedge clk);
      chk($sformatf("R7 level vec%0d", v), 32'(level), 32'(VECS[v].level));
      chk($sformatf("R1/R7 full vec%0d", v), 32'(full), 32'(VECS[v].full));
      chk($sformatf("R7 empty vec%0d", v), 32'(empty), 32'(VECS[v].empty));
      chk($sformatf("R8 overflow vec%0d", v), 32'(ovf), 32'(VECS[v].ovf));
      chk($sformatf("R9 underflow vec%0d", v), 32'(unf), 32'(VECS[v].unf));
      chk($sformatf("R5/R6/R12 rdata vec%0d", v), rdata, VECS[v].rdata);
    end
    push = 1'b0; pop = 1'b0;

    // Capacity per class, at both edges of each width band
    depth_test("R1 w8",  8,  1'b0, 4);
    depth_test("R1 w32", 32, 1'b0, 4);
    depth_test("R2 w4",  4,  1'b1, 32);
    depth_test("R2 w8",  8,  1'b1, 32);
    depth_test("R3 w9",  9,  1'b1, 16);
    depth_test("R3 w16", 16, 1'b1, 16);
    depth_test("R4 w17", 17, 1'b1, 8);
    depth_test("R4 w32", 32, 1'b1, 8);

    // R10: width change with strobes in the same cycle
    configure(16, 1'b1);
    for (int i = 0; i < 3; i++) begin
      push = 1'b1; wdata = 32'h0000_1230 + 32'(i);
      @(negedge clk);
    end
    push = 1'b0; pop = 1'b1;
    @(negedge clk);
    chk("R10 pre-flush pop", rdata, 32'h0000_1230);
    push = 1'b1; pop = 1'b1; fbits = 6'd15; wdata = 32'h7;
    @(negedge clk);
    chk("R10 level after width change", 32'(level), 32'd0);
    chk("R10 empty after width change", 32'(empty), 32'd1);
    chk("R10 rdata cleared", rdata, 32'd0);
    chk("R10 no pulses", {30'd0, ovf, unf}, 32'd0);
    push = 1'b1; pop = 1'b0; wdata = 32'hFFFF_8ABC;
    @(negedge clk);
    @(negedge clk);
    chk("R10 refill level", 32'(level), 32'd2);
    // R10: deep-mode toggle alone
    push = 1'b0; deep = 1'b0;
    @(negedge clk);
    chk("R10 level after mode change", 32'(level), 32'd0);
    pop = 1'b1;
    @(negedge clk);
    chk("R9 underflow after flush", 32'(unf), 32'd1);
    chk("R9 rdata zero", rdata, 32'd0);
    pop = 1'b0;

    // R6: 15-bit frame masking in shallow mode
    push = 1'b1; wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    push = 1'b0; pop = 1'b1;
    @(negedge clk);
    chk("R6 15-bit mask", rdata, 32'h0000_7FFF);
    pop = 1'b0;
    @(negedge clk);
    chk("R5 rdata holds", rdata, 32'h0000_7FFF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule